// File: doc/BRIEF.md
# Polled Master Frame Scheduler

This block sequences the frames that a master station sends to `N_STA` remote robot stations over a shared wireless medium. A start pulse opens a control cycle. The scheduler first requests one broadcast synchronisation frame, so that every station's control period begins on the same boundary. It then requests data frames group by group. Each group holds `GRP_SIZE` stations with consecutive addresses, and stations are numbered 1..`N_STA`. After a group's requests go out, the scheduler waits for an acknowledge from every station in that group before it moves on to the next group.

Acknowledges arrive on a single lane that carries the address of the replying station. An acknowledge counts only when it comes from a station of the current group whose reply is still outstanding. If a station stays silent for `ACK_WIN` cycles after its group's last request, the scheduler marks it in a missed-acknowledge bitmap and goes on to the next group.

A watchdog holds the control cycle to a budget of `N_STA*(SYNC_CYC+BURST_CYC*N_BURST)` clocks, counted from the sync frame. Overrunning that budget is treated as a deadlock and raises a sticky timeout flag. Modulation, CRC and payload are handled elsewhere.

Top module: `poll_sched`

## Requirements
- R1: While `rst_ni` is low, and on the first cycle after it is released, `frm_req_o`, `busy_o`, `done_o`, `timeout_o` and `missed_o` are all zero.
- R2: A `start_i` sampled high while the block is idle makes the next cycle request a sync frame: `frm_type_o`=2'd1 and `frm_dst_o`=0. A `start_i` that is high while `busy_o` is high has no effect.
- R3: Data requests carry `frm_type_o`=2'd2. One request is made per cycle, with destinations rising from 1 to `N_STA`. The first one comes in the cycle after the sync request. Each group is `GRP_SIZE` back-to-back requests.
- R4: An acknowledge (`ack_vld_i` high, `ack_src_i` = station address) is accepted only from a station of the current group whose request has already gone out and whose reply is still outstanding. Any other address, and a repeated acknowledge, is ignored.
- R5: When the last outstanding acknowledge of a group arrives in cycle `a`, the next group's first request, or `done_o`, comes in cycle `a+1`.
- R6: Let `L` be the cycle of a group's last request. An acknowledge accepted in any cycle up to and including `L+ACK_WIN` counts. Stations still silent after that cycle get their bit set in `missed_o` (bit i = station i+1), and the group is closed in cycle `L+ACK_WIN`.
- R7: `missed_o` is cleared in the cycle after the sync request and holds its value after `done_o` until the next control cycle starts.
- R8: `busy_o` is high from the sync request through the `done_o` cycle. `done_o` is a single-cycle pulse in the cycle after the last group closes. After that pulse the block is idle.
- R9: If `done_o` comes `BUDGET+2` or more cycles after the sync request, where `BUDGET = N_STA*(SYNC_CYC+BURST_CYC*N_BURST)`, then `timeout_o` is high by the `done_o` cycle. Otherwise that control cycle does not raise it. Once set, `timeout_o` stays high until reset.
- R10: `frm_req_o` is high only in sync and data request cycles. In all other cycles `frm_type_o` is 2'd0 and `frm_dst_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a control cycle (honoured only when idle) |
| ack_vld_i | input | 1 | An acknowledge frame was received this cycle |
| ack_src_i | input | ADDR_W | Address of the station that acknowledged |
| frm_req_o | output | 1 | Frame transmit request |
| frm_type_o | output | 2 | 0 none, 1 sync, 2 data |
| frm_dst_o | output | ADDR_W | Destination address, 0 for broadcast |
| busy_o | output | 1 | Control cycle in progress |
| done_o | output | 1 | Control cycle finished (one cycle) |
| missed_o | output | N_STA | Stations that did not acknowledge in this control cycle |
| timeout_o | output | 1 | Sticky budget overrun flag |

## Verification
Two events can land on the same clock: an acknowledge, and the expiry of the acknowledge window. The bench provokes this by scheduling one station's reply exactly `ACK_WIN` cycles after its group's last request, and another station's reply one cycle later. The first station must not appear in `missed_o`, and the next group must start right after that cycle. The second station must be flagged. The timeout flag is judged against the measured distance from sync to done, across runs with random and absent replies, including runs with stray and late acknowledges.

// File: rtl/poll_pkg.sv
package poll_pkg;
  typedef enum logic [1:0] {
    FT_NONE = 2'd0,
    FT_SYNC = 2'd1,
    FT_DATA = 2'd2
  } frm_type_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SYNC,
    ST_DATA,
    ST_WAIT,
    ST_DONE
  } seq_state_e;
endpackage

// File: rtl/poll_seq.sv
module poll_seq
  import poll_pkg::*;
#(
  parameter int N_STA    = 8,
  parameter int GRP_SIZE = 4,
  parameter int ACK_WIN  = 16,
  parameter int ADDR_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              all_clear_i,
  output logic              issue_o,
  output logic              sync_o,
  output logic              active_o,
  output logic              resolve_o,
  output logic              busy_o,
  output logic              done_o,
  output frm_type_e         frm_type_o,
  output logic [ADDR_W-1:0] dst_o
);
  localparam int MW = (GRP_SIZE > 1) ? $clog2(GRP_SIZE) : 1;
  localparam int WW = (ACK_WIN > 1) ? $clog2(ACK_WIN) : 1;
  localparam logic [MW-1:0]     MEM_LAST = MW'(GRP_SIZE - 1);
  localparam logic [WW-1:0]     WIN_LAST = WW'(ACK_WIN - 1);
  localparam logic [ADDR_W-1:0] DST_END  = ADDR_W'(N_STA + 1);

  seq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] dst_q;
  logic [MW-1:0]     mem_q;
  logic [WW-1:0]     win_q;
  logic              win_last, grp_end;

  assign win_last  = (win_q == WIN_LAST);
  assign grp_end   = (mem_q == MEM_LAST);
  assign resolve_o = (state_q == ST_WAIT) && (all_clear_i || win_last);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_SYNC;
      ST_SYNC: state_d = ST_DATA;
      ST_DATA: if (grp_end) state_d = ST_WAIT;
      ST_WAIT: if (resolve_o) state_d = (dst_q == DST_END) ? ST_DONE : ST_DATA;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      dst_q   <= '0;
      mem_q   <= '0;
      win_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_SYNC) begin
        dst_q <= ADDR_W'(1);
        mem_q <= '0;
      end else if (state_q == ST_DATA) begin
        dst_q <= dst_q + ADDR_W'(1);
        mem_q <= grp_end ? '0 : mem_q + MW'(1);
      end
      if (state_q == ST_WAIT && !resolve_o) win_q <= win_q + WW'(1);
      else                                  win_q <= '0;
    end
  end

  assign issue_o    = (state_q == ST_DATA);
  assign sync_o     = (state_q == ST_SYNC);
  assign active_o   = (state_q == ST_DATA) || (state_q == ST_WAIT);
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = (state_q == ST_DONE);
  assign frm_type_o = sync_o ? FT_SYNC : (issue_o ? FT_DATA : FT_NONE);
  assign dst_o      = issue_o ? dst_q : '0;

  // R2: a control cycle always opens with the broadcast sync request
  p_sync_leads_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (frm_type_o == FT_SYNC && dst_o == '0));

  // R3: data destinations stay within the station address range
  p_dst_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_o |-> (dst_o >= ADDR_W'(1) && dst_o <= ADDR_W'(N_STA)));

  // R6: the window counter never passes its last cycle
  p_win_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT) |-> (win_q <= WIN_LAST));

  // R8: done is a single-cycle pulse followed by idle
  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o));

  // R2: start is ignored mid-cycle, busy persists until done
  p_busy_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);
endmodule

// File: rtl/poll_ack_track.sv
module poll_ack_track #(
  parameter int N_STA  = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sync_i,
  input  logic              issue_i,
  input  logic [ADDR_W-1:0] issue_dst_i,
  input  logic              resolve_i,
  input  logic              ack_vld_i,
  input  logic [ADDR_W-1:0] ack_src_i,
  output logic              all_clear_o,
  output logic [N_STA-1:0]  missed_o
);
  logic [N_STA-1:0] pend_q, miss_q, hit_w;

  for (genvar i = 0; i < N_STA; i++) begin : g_slot
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(i + 1);
    logic set_w;

    // station-side style address filter: only the own address matches
    assign hit_w[i] = ack_vld_i && (ack_src_i == MY_ADDR) && pend_q[i];
    assign set_w    = issue_i && (issue_dst_i == MY_ADDR);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pend_q[i] <= 1'b0;
        miss_q[i] <= 1'b0;
      end else begin
        if (resolve_i)     pend_q[i] <= 1'b0;
        else if (set_w)    pend_q[i] <= 1'b1;
        else if (hit_w[i]) pend_q[i] <= 1'b0;

        if (sync_i)                                miss_q[i] <= 1'b0;
        else if (resolve_i && pend_q[i] && !hit_w[i]) miss_q[i] <= 1'b1;
      end
    end

    // R6: a station is only flagged if it was owed an acknowledge
    p_miss_src_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(miss_q[i]) |-> $past(pend_q[i]));
  end

  assign all_clear_o = ((pend_q & ~hit_w) == '0);
  assign missed_o    = miss_q;

  // R4: closing a group leaves nothing outstanding
  p_clear_on_close_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resolve_i |=> (pend_q == '0));

  // R7: the bitmap only changes on sync or group close
  p_miss_stable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sync_i && !resolve_i) |=> $stable(miss_q));
endmodule

// File: rtl/poll_wdog.sv
module poll_wdog #(
  parameter int BUDGET = 96
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  input  logic active_i,
  output logic timeout_o
);
  localparam int CW = $clog2(BUDGET + 1);

  logic [CW-1:0] cnt_q;
  logic          tmo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      tmo_q <= 1'b0;
    end else begin
      if (sync_i)                       cnt_q <= CW'(BUDGET);
      else if (active_i && cnt_q != '0) cnt_q <= cnt_q - CW'(1);
      if (active_i && cnt_q == '0)      tmo_q <= 1'b1;
    end
  end

  assign timeout_o = tmo_q;

  // R9: flag is sticky until reset
  p_tmo_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> timeout_o);

  // R9: flag rises only after the budget ran out mid-cycle
  p_tmo_cause_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> $past(active_i && cnt_q == '0));
endmodule

// File: rtl/poll_sched.sv
module poll_sched
  import poll_pkg::*;
#(
  parameter int N_STA     = 8,
  parameter int GRP_SIZE  = 4,
  parameter int ACK_WIN   = 16,
  parameter int SYNC_CYC  = 8,
  parameter int BURST_CYC = 4,
  parameter int N_BURST   = 1,
  localparam int ADDR_W   = $clog2(N_STA + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              ack_vld_i,
  input  logic [ADDR_W-1:0] ack_src_i,
  output logic              frm_req_o,
  output logic [1:0]        frm_type_o,
  output logic [ADDR_W-1:0] frm_dst_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [N_STA-1:0]  missed_o,
  output logic              timeout_o
);
  localparam int BUDGET = N_STA * (SYNC_CYC + BURST_CYC * N_BURST);

  logic              issue_w, sync_w, active_w, resolve_w, all_clear_w;
  frm_type_e         ftype_w;
  logic [ADDR_W-1:0] dst_w;

  poll_seq #(
    .N_STA(N_STA), .GRP_SIZE(GRP_SIZE), .ACK_WIN(ACK_WIN), .ADDR_W(ADDR_W)
  ) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .all_clear_i(all_clear_w),
    .issue_o(issue_w), .sync_o(sync_w), .active_o(active_w),
    .resolve_o(resolve_w), .busy_o(busy_o), .done_o(done_o),
    .frm_type_o(ftype_w), .dst_o(dst_w)
  );

  poll_ack_track #(.N_STA(N_STA), .ADDR_W(ADDR_W)) u_ack (
    .clk_i(clk_i), .rst_ni(rst_ni), .sync_i(sync_w),
    .issue_i(issue_w), .issue_dst_i(dst_w), .resolve_i(resolve_w),
    .ack_vld_i(ack_vld_i), .ack_src_i(ack_src_i),
    .all_clear_o(all_clear_w), .missed_o(missed_o)
  );

  poll_wdog #(.BUDGET(BUDGET)) u_wdog (
    .clk_i(clk_i), .rst_ni(rst_ni), .sync_i(sync_w),
    .active_i(active_w), .timeout_o(timeout_o)
  );

  assign frm_req_o  = issue_w || sync_w;
  assign frm_type_o = ftype_w;
  assign frm_dst_o  = dst_w;

  // R10: request strobe and type field agree
  p_req_type_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_req_o == (frm_type_o != 2'd0));
endmodule

// File: tb/tb_poll_sched.sv
module tb_poll_sched;
  localparam int N  = 8;
  localparam int G  = 4;
  localparam int AW = 48;
  localparam int SC = 8;
  localparam int BC = 4;
  localparam int NB = 1;
  localparam int ADDR_W = $clog2(N + 1);
  localparam int NEVER  = 1 << 30;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, ack_vld = 1'b0;
  logic [ADDR_W-1:0] ack_src = '0;
  logic frm_req, busy, done, tmo;
  logic [1:0] ftype;
  logic [ADDR_W-1:0] fdst;
  logic [N-1:0] missed;

  poll_sched #(.N_STA(N), .GRP_SIZE(G), .ACK_WIN(AW), .SYNC_CYC(SC),
               .BURST_CYC(BC), .N_BURST(NB)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .ack_vld_i(ack_vld),
    .ack_src_i(ack_src), .frm_req_o(frm_req), .frm_type_o(ftype),
    .frm_dst_o(fdst), .busy_o(busy), .done_o(done), .missed_o(missed),
    .timeout_o(tmo));

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  bit tmo_exp = 1'b0, fin = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  function automatic int f_budget();
    return N * (SC + BC * NB);
  endfunction

  function automatic int f_group(input int s);
    return (s - 1) / G;
  endfunction

  // mode 0 random, 1 no replies, 2 window-edge, 3 all prompt
  task automatic run_cycle(input int mode, input int miss_pct, input int dmax);
    int due[N+1];
    bit issued[N+1], deliv[N+1], okd[N+1];
    int k, exp_dst, gcnt, cur_g, L, next_k, done_k, sel;
    bit issuing, in_win, finished, all_ok;
    logic [N-1:0] exp_miss;
    for (int s = 0; s <= N; s++) begin
      due[s] = NEVER; issued[s] = 0; deliv[s] = 0; okd[s] = 0;
    end
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(frm_req && ftype == 2'd1 && fdst == '0, "R2", "sync request", ftype, 1);
    chk(busy, "R8", "busy at sync", busy, 1);
    k = 0; exp_dst = 1; gcnt = 0; cur_g = 0; L = 0; next_k = 1;
    done_k = -1; issuing = 0; in_win = 0; finished = 0;
    while (!finished && k < 1000) begin
      @(negedge clk);
      k++;
      ack_vld = 1'b0;
      start = ($urandom_range(0, 7) == 0);  // R2: ignored while busy
      if (k == 1) chk(missed == '0, "R7", "bitmap cleared at sync", missed, 0);
      if (k == next_k) issuing = 1;
      if (k == done_k) begin
        chk(done && busy && !frm_req, "R8", "done pulse", done, 1);
        for (int s = 1; s <= N; s++) exp_miss[s-1] = !okd[s];
        chk(missed == exp_miss, "R6", "missed bitmap", missed, exp_miss);
        if (k >= f_budget() + 2) tmo_exp = 1'b1;
        chk(tmo == tmo_exp, "R9", "timeout at done", tmo, tmo_exp);
        if (mode == 2) begin
          chk(!missed[G-1], "R6", "ack in last window cycle", missed[G-1], 0);
          chk(missed[N-1], "R6", "ack one cycle late", missed[N-1], 1);
        end
        finished = 1;
      end else begin
        chk(busy && !done, "R8", "busy mid-cycle", {busy, done}, 2);
        if (issuing) begin
          chk(frm_req && ftype == 2'd2 && fdst == ADDR_W'(exp_dst), "R3",
              "data request dst", fdst, exp_dst);
          issued[exp_dst] = 1;
          case (mode)
            1: due[exp_dst] = NEVER;
            2: due[exp_dst] = (exp_dst == G) ? k + AW :
                              (exp_dst == N) ? k + AW + 1 : k + 1;
            3: due[exp_dst] = k + 1;
            default: due[exp_dst] = ($urandom_range(0, 99) < miss_pct) ? NEVER :
                                    k + 1 + $urandom_range(0, dmax);
          endcase
          exp_dst++; gcnt++;
          if (gcnt == G) begin
            issuing = 0; in_win = 1; L = k; gcnt = 0;
          end
        end else begin
          chk(!frm_req && ftype == 2'd0 && fdst == '0, "R10", "no request",
              ftype, 0);
        end
      end
      if (!finished) begin
        sel = 0;
        for (int s = N; s >= 1; s--)
          if (issued[s] && !deliv[s] && due[s] <= k) sel = s;
        if (sel != 0) begin
          ack_vld = 1'b1; ack_src = ADDR_W'(sel); deliv[sel] = 1;
          if (f_group(sel) == cur_g && (issuing || in_win)) okd[sel] = 1;
        end else if ($urandom_range(0, 3) == 0) begin
          sel = $urandom_range(0, (1 << ADDR_W) - 1);
          // R4: stray, duplicate or out-of-range address; skip if still owed
          if (!(sel >= 1 && sel <= N && issued[sel] && !deliv[sel] &&
                f_group(sel) == cur_g)) begin
            ack_vld = 1'b1; ack_src = ADDR_W'(sel);
          end
        end
        if (in_win) begin
          all_ok = 1;
          for (int s = cur_g * G + 1; s <= cur_g * G + G; s++)
            if (!okd[s]) all_ok = 0;
          if (all_ok || k == L + AW) begin  // R5 / R6 close point
            in_win = 0; cur_g++;
            if (cur_g == N / G) done_k = k + 1;
            else next_k = k + 1;
          end
        end
      end
    end
    chk(finished, "R8", "cycle completed", finished, 1);
    @(negedge clk);
    start = 1'b0; ack_vld = 1'b0;
    chk(!busy && !done && !frm_req, "R8", "idle after done", busy, 0);
    chk(missed == exp_miss, "R7", "bitmap held", missed, exp_miss);
    chk(tmo == tmo_exp, "R9", "timeout sticky", tmo, tmo_exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      checks++; fails++;
      $display("FAIL R8 watchdog act=%0d exp=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(!frm_req && !busy && !done && !tmo && missed == '0, "R1",
        "outputs in reset", {frm_req, busy, done, tmo}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!frm_req && !busy && !done && !tmo && missed == '0, "R1",
        "outputs after reset", {frm_req, busy, done, tmo}, 0);
    run_cycle(3, 0, 0);
    chk(!tmo, "R9", "fast cycle in budget", tmo, 0);
    for (int r = 0; r < 12; r++) run_cycle(0, 15, 10);
    run_cycle(1, 100, 0);
    chk(tmo, "R9", "silent stations overrun budget", tmo, 1);
    run_cycle(3, 0, 0);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    tmo_exp = 1'b0;
    @(negedge clk);
    chk(!tmo && missed == '0, "R1", "timeout cleared by reset", tmo, 0);
    run_cycle(2, 0, 0);
    for (int r = 0; r < 6; r++) run_cycle(0, 40, AW + 4);
    fin = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule